// File: doc/BRIEF.md
# Escaped Binary Load-Record Receiver

This block sits behind a byte link and turns a stream of load records into memory writes. Each record is framed by a start marker and a carriage return. Between them the body carries the usual load-record fields as raw bytes instead of hex text: a byte count, a 16-bit address, a record type, the payload and a checksum. Two transformations protect the body on the link. Every original byte is XORed with 0x40. Any result that would be 0x00, 0xFF or the escape byte is then sent as a two-byte escape pair. The block reverses both steps, walks the fields and issues one write per payload byte as the byte arrives.

When a record closes, the block reports whether its checksum held. It flags an end-of-transfer record and a "file not found" record on their own outputs. A malformed escape pair, a record cut short, or surplus bytes after the checksum are reported as protocol errors, and the block then discards input until the next start marker. A progress strobe marks every 128th payload byte written and carries that byte's address, so a console can show how far a transfer has got.

Top module: `rec_stream_rx`

## Requirements
- R1: Bytes received while no record is open are ignored, except the start marker 0x3D, which opens a record. No write or event results from them. The byte 0x0D closes an open record, so an original body byte of 0x4D (0x0D after whitening) cannot be carried.
- R2: Inside a record, 0x5B introduces an escape pair. The pair 0x5B 0x41 yields 0x00, 0x5B 0x42 yields 0xFF, and 0x5B 0x5B yields 0x5B. Each yielded value then goes through the XOR of R3.
- R3: Every body byte, after escape resolution, is XORed with 0x40 to recover the original value. An unescaped 0x3D inside a record is an ordinary body byte.
- R4: The decoded body is, in order: count, address high byte, address low byte, type, count payload bytes, checksum. Payload byte i is written to address+i (16-bit wrap). wr_valid rises in the cycle after the byte's final link byte is accepted.
- R5: Only type 0x00 records produce writes. Records of any other type are parsed and checksummed but write nothing.
- R6: In the cycle after the closing 0x0D of a complete record, rec_done pulses. rec_cksum_bad is high with it exactly when the low 8 bits of the sum of all decoded body bytes (checksum included) are non-zero. Writes already issued stay issued.
- R7: rec_eof pulses together with rec_done for a type 0x01 record whose checksum holds.
- R8: rec_missing pulses together with rec_done for a type 0x99 record whose checksum holds.
- R9: An escape byte followed by anything other than 0x41, 0x42 or 0x5B pulses rec_proto_err in the cycle after that byte. Input is then ignored until the next 0x3D.
- R10: rec_proto_err also pulses, and no rec_done follows, when 0x0D arrives before the checksum byte or when a body byte arrives after the checksum.
- R11: prog_valid pulses in the cycle after every PROGRESS_EVERY-th write counted since reset, with prog_addr equal to that write's address.
- R12: in_ready and all outputs are low while rst is high. in_ready stays high once it has risen after reset, so no byte is ever refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Link byte present |
| in_ready | output | 1 | Block accepts the link byte |
| in_data | input | 8 | Link byte |
| wr_valid | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| rec_done | output | 1 | Complete record closed |
| rec_cksum_bad | output | 1 | Checksum failed, valid with rec_done |
| rec_eof | output | 1 | End-of-transfer record seen |
| rec_missing | output | 1 | File-not-found record seen |
| rec_proto_err | output | 1 | Framing or escape error |
| prog_valid | output | 1 | Progress strobe |
| prog_addr | output | 16 | Address of the write that triggered the strobe |

## Verification
The assertions watch the relations that must hold in every cycle. Writes occur only inside data records, consecutive writes step the address by one, and an end-of-transfer or not-found flag never appears without a clean record close. A protocol error always leaves the parser idle, progress strobes always follow a write, and the link is never refused. The values themselves can only be shown by the bench scenarios. These include the decoding of every escape pair, the whitening, the checksum verdict, recovery after a bad escape or a truncated record, and the exact addresses carried by progress strobes over several hundred written bytes.

// File: rtl/recrx_pkg.sv
package recrx_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MARK_OPEN  = 8'h3D;
    localparam logic [BYTE_W-1:0] MARK_CLOSE = 8'h0D;
    localparam logic [BYTE_W-1:0] ESC_LEAD   = 8'h5B;
    localparam logic [BYTE_W-1:0] ESC_ZERO   = 8'h41;
    localparam logic [BYTE_W-1:0] ESC_ONES   = 8'h42;
    localparam logic [BYTE_W-1:0] WHITEN     = 8'h40;

    localparam logic [BYTE_W-1:0] RT_DATA    = 8'h00;
    localparam logic [BYTE_W-1:0] RT_END     = 8'h01;
    localparam logic [BYTE_W-1:0] RT_MISSING = 8'h99;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_COUNT,
        PS_ADDR_HI,
        PS_ADDR_LO,
        PS_TYPE,
        PS_DATA,
        PS_CSUM,
        PS_TAIL
    } pstate_e;

    // One decoded link event per accepted byte
    typedef struct packed {
        logic              open;
        logic              body;
        logic              close;
        logic              bad_esc;
        logic [BYTE_W-1:0] value;
    } link_ev_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } mem_wr_t;

    // {legal, resolved} for the byte following an escape lead
    function automatic logic [BYTE_W:0] resolve_pair(input logic [BYTE_W-1:0] code);
        logic [BYTE_W:0] r;
        case (code)
            ESC_ZERO: r = {1'b1, 8'h00};
            ESC_ONES: r = {1'b1, 8'hFF};
            ESC_LEAD: r = {1'b1, ESC_LEAD};
            default:  r = {1'b0, 8'h00};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rec_unescape.sv
module rec_unescape
    import recrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              in_rec,
    output link_ev_t          ev
);

    logic              esc_pend;
    logic [BYTE_W:0]   pair;
    logic              pair_ok;
    logic [BYTE_W-1:0] raw_val;

    assign pair    = resolve_pair(byte_in);
    assign pair_ok = pair[BYTE_W];
    assign raw_val = esc_pend ? pair[BYTE_W-1:0] : byte_in;

    always_comb begin
        ev.open    = take && !in_rec && (byte_in == MARK_OPEN);
        ev.close   = take && in_rec && !esc_pend && (byte_in == MARK_CLOSE);
        ev.bad_esc = take && in_rec && esc_pend && !pair_ok;
        ev.body    = take && in_rec &&
                     ((esc_pend && pair_ok) ||
                      (!esc_pend && byte_in != ESC_LEAD && byte_in != MARK_CLOSE));
        ev.value   = raw_val ^ WHITEN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_pend <= 1'b0;
        end else if (!in_rec) begin
            esc_pend <= 1'b0;
        end else if (take) begin
            if (esc_pend)
                esc_pend <= 1'b0;
            else if (byte_in == ESC_LEAD)
                esc_pend <= 1'b1;
        end
    end

    // R2: at most one link event per accepted byte
    a_r2_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.open, ev.body, ev.close, ev.bad_esc}));

    // R1: nothing but an opening marker is produced outside a record
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_rec |-> !(ev.body || ev.close || ev.bad_esc));

endmodule

// File: rtl/rec_parser.sv
module rec_parser
    import recrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  link_ev_t ev,
    output logic     in_rec,
    output mem_wr_t  wr,
    output logic     done,
    output logic     cksum_bad,
    output logic     eof,
    output logic     missing,
    output logic     proto_err
);

    pstate_e           st;
    logic [BYTE_W-1:0] remain;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] rtype;
    logic [BYTE_W-1:0] sum;
    logic [BYTE_W-1:0] sum_next;
    logic              sum_zero;

    assign in_rec   = (st != PS_IDLE);
    assign sum_next = sum + ev.value;
    assign sum_zero = (sum == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PS_IDLE;
            remain    <= '0;
            addr      <= '0;
            rtype     <= '0;
            sum       <= '0;
            wr        <= '0;
            done      <= 1'b0;
            cksum_bad <= 1'b0;
            eof       <= 1'b0;
            missing   <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            wr.valid  <= 1'b0;
            done      <= 1'b0;
            cksum_bad <= 1'b0;
            eof       <= 1'b0;
            missing   <= 1'b0;
            proto_err <= 1'b0;
            if (ev.open) begin
                st  <= PS_COUNT;
                sum <= '0;
            end else if (ev.bad_esc) begin
                st        <= PS_IDLE;
                proto_err <= 1'b1;
            end else if (ev.close) begin
                st <= PS_IDLE;
                if (st == PS_TAIL) begin
                    done      <= 1'b1;
                    cksum_bad <= !sum_zero;
                    eof       <= sum_zero && (rtype == RT_END);
                    missing   <= sum_zero && (rtype == RT_MISSING);
                end else begin
                    proto_err <= 1'b1;
                end
            end else if (ev.body) begin
                sum <= sum_next;
                case (st)
                    PS_COUNT: begin
                        remain <= ev.value;
                        st     <= PS_ADDR_HI;
                    end
                    PS_ADDR_HI: begin
                        addr[ADDR_W-1:BYTE_W] <= ev.value;
                        st                    <= PS_ADDR_LO;
                    end
                    PS_ADDR_LO: begin
                        addr[BYTE_W-1:0] <= ev.value;
                        st               <= PS_TYPE;
                    end
                    PS_TYPE: begin
                        rtype <= ev.value;
                        st    <= (remain == '0) ? PS_CSUM : PS_DATA;
                    end
                    PS_DATA: begin
                        wr.valid <= (rtype == RT_DATA);
                        wr.addr  <= addr;
                        wr.data  <= ev.value;
                        addr     <= addr + 1'b1;
                        remain   <= remain - 1'b1;
                        if (remain == 8'd1)
                            st <= PS_CSUM;
                    end
                    PS_CSUM: st <= PS_TAIL;
                    PS_TAIL: begin
                        st        <= PS_IDLE;
                        proto_err <= 1'b1;
                    end
                    default: st <= PS_IDLE;
                endcase
            end
        end
    end

    a_r5_write_only_data: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> (rtype == RT_DATA));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && $past(wr.valid)) |-> (wr.addr == $past(wr.addr) + 1'b1));

    a_r6_done_not_err: assert property (@(posedge clk) disable iff (rst)
        !(done && proto_err));

    a_r7_eof_clean: assert property (@(posedge clk) disable iff (rst)
        eof |-> (done && !cksum_bad));

    a_r8_missing_clean: assert property (@(posedge clk) disable iff (rst)
        missing |-> (done && !cksum_bad));

    a_r9_err_to_idle: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !in_rec);

endmodule

// File: rtl/rec_progress.sv
module rec_progress
    import recrx_pkg::*;
#(
    parameter int EVERY = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              prog,
    output logic [ADDR_W-1:0] prog_addr
);

    localparam int CW = (EVERY > 1) ? $clog2(EVERY) : 1;
    localparam logic [CW-1:0] LAST = CW'(EVERY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            prog      <= 1'b0;
            prog_addr <= '0;
        end else begin
            prog <= 1'b0;
            if (wr_fire) begin
                if (cnt == LAST) begin
                    cnt       <= '0;
                    prog      <= 1'b1;
                    prog_addr <= wr_addr;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    a_r11_prog_follows_write: assert property (@(posedge clk) disable iff (rst)
        prog |-> ($past(wr_fire) && prog_addr == $past(wr_addr)));

endmodule

// File: rtl/rec_stream_rx.sv
module rec_stream_rx
    import recrx_pkg::*;
#(
    parameter int PROGRESS_EVERY = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rec_done,
    output logic              rec_cksum_bad,
    output logic              rec_eof,
    output logic              rec_missing,
    output logic              rec_proto_err,
    output logic              prog_valid,
    output logic [ADDR_W-1:0] prog_addr
);

    logic     rdy_q;
    logic     take;
    logic     in_rec;
    link_ev_t ev;
    mem_wr_t  wr;

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= 1'b1;
    end

    assign in_ready = rdy_q;
    assign take     = in_valid && rdy_q;

    rec_unescape u_unesc (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .byte_in (in_data),
        .in_rec  (in_rec),
        .ev      (ev)
    );

    rec_parser u_parse (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .in_rec    (in_rec),
        .wr        (wr),
        .done      (rec_done),
        .cksum_bad (rec_cksum_bad),
        .eof       (rec_eof),
        .missing   (rec_missing),
        .proto_err (rec_proto_err)
    );

    rec_progress #(.EVERY(PROGRESS_EVERY)) u_prog (
        .clk       (clk),
        .rst       (rst),
        .wr_fire   (wr.valid),
        .wr_addr   (wr.addr),
        .prog      (prog_valid),
        .prog_addr (prog_addr)
    );

    assign wr_valid = wr.valid;
    assign wr_addr  = wr.addr;
    assign wr_data  = wr.data;

    a_r12_ready_held: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> in_ready);

    a_r6_bad_only_with_done: assert property (@(posedge clk) disable iff (rst)
        rec_cksum_bad |-> rec_done);

endmodule

// File: tb/rec_stream_rx_bench.sv
module rec_stream_rx_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_data;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        rec_done, rec_cksum_bad, rec_eof, rec_missing, rec_proto_err;
    logic        prog_valid;
    logic [15:0] prog_addr;

    always #4 clk = ~clk;

    rec_stream_rx #(.PROGRESS_EVERY(128)) u_rec_stream_rx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rec_done(rec_done), .rec_cksum_bad(rec_cksum_bad), .rec_eof(rec_eof),
        .rec_missing(rec_missing), .rec_proto_err(rec_proto_err),
        .prog_valid(prog_valid), .prog_addr(prog_addr)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [23:0] exp_w[$];
    logic [23:0] obs_w[$];
    logic [15:0] exp_p[$];
    logic [15:0] obs_p[$];
    int exp_done = 0, obs_done = 0;
    int exp_bad = 0, obs_bad = 0;
    int exp_eof = 0, obs_eof = 0;
    int exp_miss = 0, obs_miss = 0;
    int exp_err = 0, obs_err = 0;
    int wr_count = 0;
    logic [7:0] pay[256];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid)      obs_w.push_back({wr_addr, wr_data});
            if (prog_valid)    obs_p.push_back(prog_addr);
            if (rec_done)      obs_done++;
            if (rec_cksum_bad) obs_bad++;
            if (rec_eof)       obs_eof++;
            if (rec_missing)   obs_miss++;
            if (rec_proto_err) obs_err++;
        end
    end

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        exp_w.push_back({a, d});
        wr_count++;
        if (wr_count % 128 == 0) exp_p.push_back(a);
    endtask

    task automatic emit(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        if (($urandom & 3) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Whitening then escaping, as the link sender does
    task automatic send_body(input logic [7:0] b);
        logic [7:0] v;
        v = b ^ 8'h40;
        if (v == 8'h00)      begin emit(8'h5B); emit(8'h41); end
        else if (v == 8'hFF) begin emit(8'h5B); emit(8'h42); end
        else if (v == 8'h5B) begin emit(8'h5B); emit(8'h5B); end
        else                 emit(v);
    endtask

    function automatic logic [7:0] pick();
        logic [7:0] v;
        v = 8'($urandom);
        if (v == 8'h4D) v = 8'h4E;
        return v;
    endfunction

    task automatic send_record(input logic [7:0] typ, input logic [15:0] a,
                               input int cnt, input bit bad, input bit given);
        logic [7:0] d[256];
        logic [7:0] s, ck;
        bit ok;
        ok = 0;
        while (!ok) begin
            s = 8'(cnt) + a[15:8] + a[7:0] + typ;
            for (int i = 0; i < cnt; i++) begin
                d[i] = given ? pay[i] : pick();
                s = s + d[i];
            end
            ck = 8'h00 - s;
            if (bad) ck = ck ^ 8'h01;
            ok = (ck != 8'h4D) || given;
        end
        emit(8'h3D);
        send_body(8'(cnt));
        send_body(a[15:8]);
        send_body(a[7:0]);
        send_body(typ);
        for (int i = 0; i < cnt; i++) send_body(d[i]);
        send_body(ck);
        emit(8'h0D);
        if (typ == 8'h00)
            for (int i = 0; i < cnt; i++) model_write(a + 16'(i), d[i]);
        exp_done++;
        if (bad) exp_bad++;
        else if (typ == 8'h01) exp_eof++;
        else if (typ == 8'h99) exp_miss++;
    endtask

    task automatic flush_compare(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(req, "write count", obs_w.size(), exp_w.size());
        while (exp_w.size() > 0 && obs_w.size() > 0)
            chk(req, "write addr/data", obs_w.pop_front(), exp_w.pop_front());
        exp_w.delete();
        obs_w.delete();
        chk(req, "progress count", obs_p.size(), exp_p.size());
        while (exp_p.size() > 0 && obs_p.size() > 0)
            chk("R11", "progress addr", obs_p.pop_front(), exp_p.pop_front());
        exp_p.delete();
        obs_p.delete();
        chk(req, "done pulses", obs_done, exp_done);
        chk("R6", "checksum-bad pulses", obs_bad, exp_bad);
        chk("R7", "eof pulses", obs_eof, exp_eof);
        chk("R8", "missing pulses", obs_miss, exp_miss);
        chk(req, "protocol-error pulses", obs_err, exp_err);
    endtask

    function automatic logic [15:0] pick_addr();
        return {pick(), pick()};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        void'($urandom(32'h5EED_0123));
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = 8'h00;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "in_ready in reset", in_ready, 0);
        chk("R12", "outputs in reset",
            {wr_valid, rec_done, rec_cksum_bad, rec_eof, rec_missing, rec_proto_err, prog_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "in_ready after reset", in_ready, 1);

        // R1: garbage outside a record, including close and escape bytes
        for (int i = 0; i < 24; i++) begin
            g = 8'($urandom);
            if (g == 8'h3D) g = 8'h0D;
            if (i == 3) g = 8'h5B;
            emit(g);
        end
        flush_compare("R1");

        // R2 R3 R4: every escape pair and an in-record 0x3D
        pay[0] = 8'h40; pay[1] = 8'hBF; pay[2] = 8'h1B; pay[3] = 8'h7D;
        pay[4] = 8'h00; pay[5] = 8'hFF; pay[6] = 8'h5B; pay[7] = 8'h12;
        send_record(8'h00, 16'h1234, 8, 0, 1);
        flush_compare("R2");

        // R4: address wrap and a zero-length record
        send_record(8'h00, 16'hFFFE, 4, 0, 0);
        send_record(8'h00, 16'h0100, 0, 0, 0);
        flush_compare("R4");

        // R5: other types write nothing
        send_record(8'h05, 16'h2000, 6, 0, 0);
        send_record(8'h37, 16'h2100, 3, 0, 0);
        flush_compare("R5");

        // R6: bad checksum, writes still happen
        send_record(8'h00, 16'h3000, 5, 1, 0);
        flush_compare("R6");

        // R7 R8 and a bad-checksum end record
        send_record(8'h01, 16'h0000, 0, 0, 0);
        send_record(8'h99, 16'h0000, 0, 0, 0);
        send_record(8'h01, 16'h0000, 0, 1, 0);
        flush_compare("R7");

        // R9: illegal escape follower, then bytes ignored, then recovery
        emit(8'h3D);
        send_body(8'd4); send_body(8'h40); send_body(8'h10); send_body(8'h00);
        send_body(8'hA5);
        model_write(16'h4010, 8'hA5);
        emit(8'h5B); emit(8'h5A);
        exp_err++;
        emit(8'h11); emit(8'h5B); emit(8'h22); emit(8'h0D);
        send_record(8'h00, 16'h4100, 3, 0, 0);
        flush_compare("R9");

        // R10: early close
        emit(8'h3D);
        send_body(8'd5); send_body(8'h50); send_body(8'h00); send_body(8'h00);
        send_body(8'h01); send_body(8'h02);
        model_write(16'h5000, 8'h01);
        model_write(16'h5001, 8'h02);
        emit(8'h0D);
        exp_err++;
        flush_compare("R10");

        // R10: surplus body byte after the checksum
        emit(8'h3D);
        send_body(8'd1); send_body(8'h60); send_body(8'h00); send_body(8'h00);
        send_body(8'h9F);
        model_write(16'h6000, 8'h9F);
        send_body(8'h00 - (8'd1 + 8'h60 + 8'h9F));
        send_body(8'h22);
        emit(8'h0D);
        exp_err++;
        flush_compare("R10");

        // R11: random data records across several progress boundaries
        for (int r = 0; r < 14; r++) begin
            send_record(8'h00, pick_addr(), 10 + int'($urandom % 30), ($urandom % 5) == 0, 0);
            if (r % 4 == 3) flush_compare("R11");
        end
        flush_compare("R11");
        chk("R11", "enough writes for strobes", wr_count >= 256, 1);
        chk("R12", "in_ready still high", in_ready, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule